// File: doc/BRIEF.md
# Video Line and Field Timebase

This block keeps the horizontal and vertical timing of a video stream: a sample counter within the line, a line counter within the frame, a field flag, a colour frame phase and blanking strobes. In master mode it runs on its own at nominal line length and frame height and drives sync strobes onto two bidirectional pins. In slave mode it watches those pins and realigns its counters to their active edges.

Each reference input is qualified by a programmable active polarity and then delayed by a programmable number of sample clocks before it acts. The delay is held in a small state machine per input with two states. `DLY_IDLE` waits for a qualified edge. It goes to `DLY_WAIT` when an edge arrives with a non-zero delay, or fires at once when the delay is zero. `DLY_WAIT` reloads itself on a fresh edge, counts down otherwise, and returns to `DLY_IDLE` when it fires at a count of one. Between edges, and when edges are missing, the counters keep running at nominal timing. An edge at an unexpected phase is applied as soon as its delay expires.

The second pin has four roles, picked from the mode and configuration:
- `ROLE_HREF_IN`: horizontal reference input.
- `ROLE_BLANK_IN`: blanking input.
- `ROLE_BLANK_OUT`: blanking output.
- `ROLE_HSYNC_OUT`: horizontal sync output.

Top module: `vid_timebase`

## Requirements
- R1: With no reference edges the sample counter counts 0 to SPL-1 and wraps, and the line counter advances on each wrap over 0 to LINES-1. The standard select at 0 gives SPL=SPL_A and LINES=LINES_A (1716 and 525 by default). At 1 it gives SPL_B and LINES_B (1728 and 625).
- R2: `field_odd` is 1 on lines below HALF=(LINES+1)/2 and 0 from HALF upward.
- R3: `cframe_phase` advances by one each time the line counter enters line 0. It counts modulo 2 for the 525-line standard and modulo 4 for the 625-line standard.
- R4: An input's active edge is its rising edge when its polarity bit is 0 and its falling edge when the bit is 1. The opposite edge has no effect.
- R5: If a pin's active level is first sampled at clock edge k and its delay is D (0 to 1023), the realignment shows on the counters after edge k+1+D.
- R6: A vertical event with phase initialisation off sets the line to 0 if the current line is at or above HALF, else to HALF, with R3 applying on entry to 0. With initialisation on it sets the line to 0 and `cframe_phase` to 0.
- R7: With horizontal-from-vertical set, a vertical event also sets the sample counter to 0. Otherwise an event from the second pin, using its own polarity and delay, sets the sample counter to 0 and advances the line as a wrap would.
- R8: Any number of missing reference edges leaves the counters free-running at nominal timing without disturbance.
- R9: In master mode input edges are ignored. `sync_v_oe` is 1 and `sync_v_out` is high on lines 0 and HALF. `sync_aux_oe` is 1, and `sync_aux_out` is high for samples below HSYNC_W, or carries blanking when horizontal-from-vertical is set.
- R10: In slave mode with horizontal-from-vertical set, the second pin is a blanking output when `cfg_aux_drive` is 1: `sync_aux_oe`=1, with the output set to `hblank`, or `hblank|vblank` when `cfg_aux_comp` is 1. Otherwise it is a blanking input whose active level (per `cfg_href_pol`) ORs into `blank_out`. Output enables and outputs are 0 when not driving.
- R11: `hblank` is high for samples below HBLANK_W. `vblank` is high on the first VBLANK_L lines of each field, starting at line 0 and at HALF. `blank_out` is `hblank|vblank|`external blank.
- R12: During reset the sample count, line count and colour frame phase are 0 and `field_odd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = master (free-run, drive pins), 0 = slave |
| cfg_std625 | input | 1 | 0 = SPL_A/LINES_A standard, 1 = SPL_B/LINES_B |
| cfg_vref_pol | input | 1 | Vertical pin polarity, 1 = falling edge active |
| cfg_vref_dly | input | DLY_W | Vertical pin delay in samples |
| cfg_href_pol | input | 1 | Second pin polarity (reference or blank input) |
| cfg_href_dly | input | DLY_W | Second pin delay in samples |
| cfg_h_from_vref | input | 1 | Take horizontal phase from the vertical pin |
| cfg_init_phase | input | 1 | Vertical event also initialises field and colour frame |
| cfg_aux_drive | input | 1 | Slave, horizontal-from-vertical: second pin drives blanking |
| cfg_aux_comp | input | 1 | Blanking output is composite instead of horizontal |
| sync_v_in | input | 1 | Vertical reference pin, input side |
| sync_v_out | output | 1 | Vertical pin, output side |
| sync_v_oe | output | 1 | Vertical pin output enable |
| sync_aux_in | input | 1 | Second pin, input side |
| sync_aux_out | output | 1 | Second pin, output side |
| sync_aux_oe | output | 1 | Second pin output enable |
| sample_cnt | output | SW | Sample within line (11 bits by default) |
| line_cnt | output | LW | Line within frame (10 bits by default) |
| field_odd | output | 1 | 1 in the first field |
| cframe_phase | output | 2 | Colour frame phase |
| hblank | output | 1 | Horizontal blanking strobe |
| vblank | output | 1 | Vertical blanking strobe |
| blank_out | output | 1 | Composite blanking including external input |

## Verification
The slave sweep covers both standards, both polarities and delays of 0, 1, 3 and 7, with phase initialisation and horizontal-from-vertical each on and off.
- Vertical edges landing below and above the field midpoint tell the two realignment branches apart, and show when the colour phase resets versus advances.
- Edges on the second pin at off-nominal phases show that a horizontal event acts as an early line wrap.
- Long stretches without edges show that the flywheel holds timing.
- Pulses of the opposite polarity show that the trailing edge has no effect.

Master runs apply vertical pulses that must be ignored. Runs with the second pin as a blanking input or output separate the horizontal and composite blanking selections.

// File: rtl/vtb_pkg.sv
package vtb_pkg;

    typedef enum logic {
        DLY_IDLE,
        DLY_WAIT
    } dly_state_e;

    typedef enum logic [1:0] {
        ROLE_HREF_IN,
        ROLE_BLANK_IN,
        ROLE_BLANK_OUT,
        ROLE_HSYNC_OUT
    } aux_role_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vtb_edge_delay.sv
module vtb_edge_delay
    import vtb_pkg::*;
#(
    parameter int DLY_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    input  logic             pol,
    input  logic [DLY_W-1:0] dly,
    output logic             evt
);

    logic             lvl_q, lvl_d, edge_hit;
    dly_state_e       state, state_n;
    logic [DLY_W-1:0] cnt, cnt_n;

    // level qualified by polarity, then edge detect
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            lvl_d <= 1'b0;
        end else begin
            lvl_q <= pin ^ pol;
            lvl_d <= lvl_q;
        end
    end

    assign edge_hit = lvl_q & ~lvl_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= DLY_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        evt     = 1'b0;
        unique case (state)
            DLY_IDLE: begin
                if (edge_hit) begin
                    if (dly == '0) begin
                        evt = 1'b1;
                    end else begin
                        state_n = DLY_WAIT;
                        cnt_n   = dly;
                    end
                end
            end
            DLY_WAIT: begin
                if (edge_hit) begin
                    if (dly == '0) begin
                        evt     = 1'b1;
                        state_n = DLY_IDLE;
                    end else begin
                        cnt_n = dly;
                    end
                end else if (cnt == DLY_W'(1)) begin
                    evt     = 1'b1;
                    state_n = DLY_IDLE;
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            default: state_n = DLY_IDLE;
        endcase
    end

    // R5
    wait_cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DLY_WAIT) |-> (cnt != '0));

    // R5
    unit_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit && dly == DLY_W'(1)) |=> evt);

endmodule

// File: rtl/vtb_counter.sv
module vtb_counter #(
    parameter int SW = 11,
    parameter int LW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] spl_m1,
    input  logic [LW-1:0] lines_m1,
    input  logic [LW-1:0] half,
    input  logic [1:0]    cf_m1,
    input  logic          init,
    input  logic          h_evt,
    input  logic          v_evt,
    output logic [SW-1:0] sample,
    output logic [LW-1:0] line,
    output logic [1:0]    cf
);

    logic          wrap;
    logic [SW-1:0] sample_n;
    logic [LW-1:0] line_n, line_adv;
    logic [1:0]    cf_n, cf_adv;

    always_comb begin
        wrap     = (sample >= spl_m1);
        sample_n = (h_evt || wrap) ? '0 : sample + 1'b1;
        line_adv = (line >= lines_m1) ? '0 : line + 1'b1;
        cf_adv   = (cf >= cf_m1) ? 2'd0 : cf + 2'd1;
        line_n   = line;
        cf_n     = cf;
        if (v_evt) begin
            if (init) begin
                line_n = '0;
                cf_n   = 2'd0;
            end else if (line >= half) begin
                line_n = '0;
                cf_n   = cf_adv;
            end else begin
                line_n = half;
            end
        end else if (h_evt || wrap) begin
            line_n = line_adv;
            if (line >= lines_m1) cf_n = cf_adv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample <= '0;
            line   <= '0;
            cf     <= 2'd0;
        end else begin
            sample <= sample_n;
            line   <= line_n;
            cf     <= cf_n;
        end
    end

    // R1
    sample_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_evt && sample < spl_m1) |=> (sample == $past(sample) + 1'b1));

    // R7
    href_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_evt |=> (sample == '0));

    // R6
    init_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_evt && init) |=> (line == '0 && cf == 2'd0));

    // R8
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_evt && !v_evt && sample < spl_m1) |=> $stable(line));

endmodule

// File: rtl/vid_timebase.sv
module vid_timebase
    import vtb_pkg::*;
#(
    parameter int SPL_A    = 1716,
    parameter int LINES_A  = 525,
    parameter int SPL_B    = 1728,
    parameter int LINES_B  = 625,
    parameter int HBLANK_W = 276,
    parameter int HSYNC_W  = 126,
    parameter int VBLANK_L = 20,
    parameter int DLY_W    = 10,
    localparam int SW      = $clog2(max2(SPL_A, SPL_B)),
    localparam int LW      = $clog2(max2(LINES_A, LINES_B))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_master,
    input  logic             cfg_std625,
    input  logic             cfg_vref_pol,
    input  logic [DLY_W-1:0] cfg_vref_dly,
    input  logic             cfg_href_pol,
    input  logic [DLY_W-1:0] cfg_href_dly,
    input  logic             cfg_h_from_vref,
    input  logic             cfg_init_phase,
    input  logic             cfg_aux_drive,
    input  logic             cfg_aux_comp,
    input  logic             sync_v_in,
    output logic             sync_v_out,
    output logic             sync_v_oe,
    input  logic             sync_aux_in,
    output logic             sync_aux_out,
    output logic             sync_aux_oe,
    output logic [SW-1:0]    sample_cnt,
    output logic [LW-1:0]    line_cnt,
    output logic             field_odd,
    output logic [1:0]       cframe_phase,
    output logic             hblank,
    output logic             vblank,
    output logic             blank_out
);

    localparam int HALF_A = (LINES_A + 1) / 2;
    localparam int HALF_B = (LINES_B + 1) / 2;

    logic          v_raw, a_raw, v_evt, h_evt, ext_blank, hsync;
    logic [SW-1:0] spl_m1;
    logic [LW-1:0] lines_m1, half;
    logic [1:0]    cf_m1;
    aux_role_e     role;

    vtb_edge_delay #(.DLY_W(DLY_W)) u_vdly (
        .clk(clk), .rst_n(rst_n), .pin(sync_v_in), .pol(cfg_vref_pol),
        .dly(cfg_vref_dly), .evt(v_raw));

    vtb_edge_delay #(.DLY_W(DLY_W)) u_adly (
        .clk(clk), .rst_n(rst_n), .pin(sync_aux_in), .pol(cfg_href_pol),
        .dly(cfg_href_dly), .evt(a_raw));

    always_comb begin
        spl_m1   = cfg_std625 ? SW'(SPL_B - 1) : SW'(SPL_A - 1);
        lines_m1 = cfg_std625 ? LW'(LINES_B - 1) : LW'(LINES_A - 1);
        half     = cfg_std625 ? LW'(HALF_B) : LW'(HALF_A);
        cf_m1    = cfg_std625 ? 2'd3 : 2'd1;
    end

    always_comb begin
        if (!cfg_h_from_vref)
            role = cfg_master ? ROLE_HSYNC_OUT : ROLE_HREF_IN;
        else if (cfg_master || cfg_aux_drive)
            role = ROLE_BLANK_OUT;
        else
            role = ROLE_BLANK_IN;
    end

    assign v_evt = !cfg_master && v_raw;
    assign h_evt = (role == ROLE_HREF_IN) ? a_raw : (v_evt && cfg_h_from_vref);

    vtb_counter #(.SW(SW), .LW(LW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .spl_m1(spl_m1), .lines_m1(lines_m1),
        .half(half), .cf_m1(cf_m1), .init(cfg_init_phase), .h_evt(h_evt),
        .v_evt(v_evt), .sample(sample_cnt), .line(line_cnt), .cf(cframe_phase));

    always_comb begin
        field_odd = (line_cnt < half);
        hblank    = (sample_cnt < SW'(HBLANK_W));
        hsync     = (sample_cnt < SW'(HSYNC_W));
        vblank    = (line_cnt < LW'(VBLANK_L)) ||
                    (line_cnt >= half && line_cnt < half + LW'(VBLANK_L));
        sync_v_oe  = cfg_master;
        sync_v_out = cfg_master && (line_cnt == '0 || line_cnt == half);
    end

    always_comb begin
        sync_aux_oe  = 1'b0;
        sync_aux_out = 1'b0;
        ext_blank    = 1'b0;
        unique case (role)
            ROLE_HREF_IN: ;
            ROLE_BLANK_IN:  ext_blank = sync_aux_in ^ cfg_href_pol;
            ROLE_BLANK_OUT: begin
                sync_aux_oe  = 1'b1;
                sync_aux_out = cfg_aux_comp ? (hblank | vblank) : hblank;
            end
            ROLE_HSYNC_OUT: begin
                sync_aux_oe  = 1'b1;
                sync_aux_out = hsync;
            end
            default: ;
        endcase
        blank_out = hblank | vblank | ext_blank;
    end

    // R9
    master_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && $stable(cfg_master) && sample_cnt < spl_m1) |=>
        (sample_cnt == $past(sample_cnt) + 1'b1));

endmodule

// File: tb/vid_timebase_tb.sv
module vid_timebase_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SPLA = 20, LNA = 9, SPLB = 24, LNB = 11;
    localparam int HBW = 4, HSW = 2, VBL = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_master = 0, cfg_std625 = 0, cfg_vref_pol = 0, cfg_href_pol = 0;
    logic [9:0] cfg_vref_dly = '0, cfg_href_dly = '0;
    logic cfg_h_from_vref = 0, cfg_init_phase = 0, cfg_aux_drive = 0, cfg_aux_comp = 0;
    logic sync_v_in = 0, sync_aux_in = 0;
    logic sync_v_out, sync_v_oe, sync_aux_out, sync_aux_oe;
    logic [4:0] sample_cnt;
    logic [3:0] line_cnt;
    logic field_odd, hblank, vblank, blank_out;
    logic [1:0] cframe_phase;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    string scen = "";

    // bench model state
    int m_s, m_l, m_c, spl, lines, half, cfm, vc, ac;
    bit v_flag, a_flag, v_act, a_act;

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_timebase #(.SPL_A(SPLA), .LINES_A(LNA), .SPL_B(SPLB), .LINES_B(LNB),
                   .HBLANK_W(HBW), .HSYNC_W(HSW), .VBLANK_L(VBL), .DLY_W(10)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_std625(cfg_std625),
        .cfg_vref_pol(cfg_vref_pol), .cfg_vref_dly(cfg_vref_dly),
        .cfg_href_pol(cfg_href_pol), .cfg_href_dly(cfg_href_dly),
        .cfg_h_from_vref(cfg_h_from_vref), .cfg_init_phase(cfg_init_phase),
        .cfg_aux_drive(cfg_aux_drive), .cfg_aux_comp(cfg_aux_comp),
        .sync_v_in(sync_v_in), .sync_v_out(sync_v_out), .sync_v_oe(sync_v_oe),
        .sync_aux_in(sync_aux_in), .sync_aux_out(sync_aux_out), .sync_aux_oe(sync_aux_oe),
        .sample_cnt(sample_cnt), .line_cnt(line_cnt), .field_odd(field_odd),
        .cframe_phase(cframe_phase), .hblank(hblank), .vblank(vblank), .blank_out(blank_out));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", tag, scen, act, exp);
        end
    endtask

    task automatic model_step();
        bit vf = 0, af = 0, hf, wrap;
        int ns, nl, nc;
        if (vc > 0) begin vc--; if (vc == 0) vf = 1; end
        if (v_flag) begin vc = int'(cfg_vref_dly) + 1; v_flag = 0; end
        if (ac > 0) begin ac--; if (ac == 0) af = 1; end
        if (a_flag) begin ac = int'(cfg_href_dly) + 1; a_flag = 0; end
        if (cfg_master) begin vf = 0; af = 0; end
        hf = cfg_h_from_vref ? vf : af;
        wrap = (m_s == spl - 1);
        ns = (hf || wrap) ? 0 : m_s + 1;
        nl = m_l; nc = m_c;
        if (vf) begin
            if (cfg_init_phase) begin nl = 0; nc = 0; end
            else if (m_l >= half) begin nl = 0; nc = (m_c + 1) % cfm; end
            else nl = half;
        end else if (hf || wrap) begin
            nl = (m_l + 1) % lines;
            if (nl == 0) nc = (m_c + 1) % cfm;
        end
        m_s = ns; m_l = nl; m_c = nc;
    endtask

    task automatic compare_all();
        bit hb, vb, ext, aoe, aout;
        hb  = (m_s < HBW);
        vb  = (m_l < VBL) || (m_l >= half && m_l < half + VBL);
        ext = !cfg_master && cfg_h_from_vref && !cfg_aux_drive && (sync_aux_in ^ cfg_href_pol);
        aoe = cfg_master || (cfg_h_from_vref && cfg_aux_drive);
        if (!cfg_h_from_vref && cfg_master) aout = (m_s < HSW);
        else if (aoe) aout = cfg_aux_comp ? (hb | vb) : hb;
        else aout = 0;
        chk("R1 sample", int'(sample_cnt), m_s);
        chk("R1 line", int'(line_cnt), m_l);
        chk("R2 field", int'(field_odd), int'(m_l < half));
        chk("R3 cframe", int'(cframe_phase), m_c);
        chk("R11 hblank", int'(hblank), int'(hb));
        chk("R11 vblank", int'(vblank), int'(vb));
        chk("R11 blank_out", int'(blank_out), int'(hb | vb | ext));
        chk("R9 v_oe", int'(sync_v_oe), int'(cfg_master));
        chk("R9 v_out", int'(sync_v_out), int'(cfg_master && (m_l == 0 || m_l == half)));
        chk("R10 aux_oe", int'(sync_aux_oe), int'(aoe));
        chk("R10 aux_out", int'(sync_aux_out), int'(aout));
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic set_v(input bit act);
        if (act && !v_act) v_flag = 1;
        v_act = act;
        sync_v_in = act ^ cfg_vref_pol;
    endtask

    task automatic set_a(input bit act);
        if (act && !a_act) a_flag = 1;
        a_act = act;
        sync_aux_in = act ^ cfg_href_pol;
    endtask

    task automatic pulse_v();
        set_v(1); repeat (3) tick(); set_v(0); tick();
    endtask

    task automatic pulse_a(input int len);
        set_a(1); repeat (len) tick(); set_a(0); tick();
    endtask

    task automatic do_reset();
        string keep;
        @(negedge clk);
        rst_n = 0;
        spl   = cfg_std625 ? SPLB : SPLA;
        lines = cfg_std625 ? LNB : LNA;
        half  = (lines + 1) / 2;
        cfm   = cfg_std625 ? 4 : 2;
        m_s = 0; m_l = 0; m_c = 0; vc = 0; ac = 0;
        v_flag = 0; a_flag = 0; v_act = 0; a_act = 0;
        sync_v_in = cfg_vref_pol;
        sync_aux_in = cfg_href_pol;
        @(negedge clk);
        keep = scen;
        scen = {"R12 reset / ", keep};
        compare_all();
        chk("R12 field_odd at reset", int'(field_odd), 1);
        scen = keep;
        rst_n = 1;
    endtask

    task automatic run_slave(input bit std, input bit vp, input int d, input bit ini, input bit hf);
        cfg_master = 0; cfg_std625 = std; cfg_vref_pol = vp; cfg_vref_dly = 10'(d);
        cfg_href_pol = !vp; cfg_href_dly = (d == 0) ? 10'd2 : 10'(d - 1);
        cfg_init_phase = ini; cfg_h_from_vref = hf; cfg_aux_drive = 0; cfg_aux_comp = 0;
        scen = "R4 R5 R6 R7 R8 slave sweep";
        do_reset();
        repeat (25) tick();
        pulse_v();
        repeat (40) tick();
        if (!hf) begin
            pulse_a(3); repeat (30) tick(); pulse_a(3); repeat (10) tick();
        end
        repeat (spl * lines + 15) tick();
        pulse_v();
        repeat (spl * 3 + 7) tick();
        pulse_v();
        repeat (60) tick();
    endtask

    task automatic run_master(input bit std, input bit hf, input bit comp);
        cfg_master = 1; cfg_std625 = std; cfg_vref_pol = 0; cfg_vref_dly = 10'd1;
        cfg_href_pol = 0; cfg_href_dly = 10'd0; cfg_init_phase = 1;
        cfg_h_from_vref = hf; cfg_aux_drive = 0; cfg_aux_comp = comp;
        scen = "R9 R10 master";
        do_reset();
        repeat (30) tick();
        pulse_v();
        repeat (spl * lines + 30) tick();
    endtask

    task automatic run_blank(input bit drive, input bit comp);
        cfg_master = 0; cfg_std625 = 0; cfg_vref_pol = 0; cfg_vref_dly = 10'd1;
        cfg_href_pol = 1; cfg_href_dly = 10'd0; cfg_init_phase = 0;
        cfg_h_from_vref = 1; cfg_aux_drive = drive; cfg_aux_comp = comp;
        scen = "R7 R10 R11 aux blank role";
        do_reset();
        repeat (20) tick();
        if (!drive) pulse_a(5);
        repeat (10) tick();
        pulse_v();
        repeat (30) tick();
        if (!drive) pulse_a(7);
        repeat (spl * lines) tick();
    endtask

    initial begin
        int dlys[4] = '{0, 1, 3, 7};
        for (int s = 0; s < 2; s++)
            for (int p = 0; p < 2; p++)
                for (int di = 0; di < 4; di++)
                    for (int i = 0; i < 2; i++)
                        for (int h = 0; h < 2; h++)
                            run_slave(s[0], p[0], dlys[di], i[0], h[0]);
        for (int s = 0; s < 2; s++)
            for (int h = 0; h < 2; h++)
                for (int c = 0; c < 2; c++)
                    run_master(s[0], h[0], c[0]);
        for (int dr = 0; dr < 2; dr++)
            for (int c = 0; c < 2; c++)
                run_blank(dr[0], c[0]);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule